// File: doc/BRIEF.md
# Threshold-Triggered DMA Write Engine

This block sits between a deserializer and a host memory write path. Incoming data words are collected in a receive FIFO. Software programs a destination byte address and a transfer size in bytes through a small register port. As soon as the FIFO holds at least the programmed number of words, the engine starts a transfer without any further command. It drains exactly that many words into host memory as a series of write bursts.

Each burst goes out on a single request stream. The first beat of a burst carries the burst start address and its length in beats. Every beat carries one data word, and the final beat of the burst is flagged. The burst splitter keeps every burst within a configurable beat limit and never lets one straddle an aligned 4 KB address line. The address and size are captured when a transfer starts, so software may reprogram them for the next block while the current one is still draining. Completion is reported through a sticky status bit and a one-cycle interrupt pulse. FIFO overflow is reported through a sticky error bit.

Top module: `thr_dma_wr`

## Requirements
- R1: After reset, `wr_valid` and `irq` are 0, and all four readable registers (destination, size, status, fill) read 0.
- R2: The register select codes are 0 = destination byte address, 1 = size in bytes, 2 = status and 3 = FIFO fill in words (read-only). Writes to 0 and 1 read back unchanged on `cfg_rd_data`, which is combinational on `cfg_rd_sel`. Bits [1:0] of both the address and the size are ignored by the engine.
- R3: While no transfer is active, a transfer starts if the size in words (size >> 2) is nonzero and the fill is at or above it. With one word fewer than that in the FIFO, no beat is issued.
- R4: A size below 4 bytes (zero words) never starts a transfer, and received words stay in the FIFO.
- R5: A transfer issues exactly size>>2 beats. The beats carry the received words in arrival order, to consecutive word addresses starting at the destination with bits [1:0] cleared.
- R6: Each burst takes the largest length that is at most MAX_BURST, at most the words left, and at most the words left before the next 4096-byte line. `wr_sop` marks its first beat, where `wr_addr` and `wr_len` are valid. `wr_last` marks its final beat.
- R7: Destination and size are captured when a transfer starts. Register writes made while the transfer is in progress (status bit 2 = busy) affect only later transfers.
- R8: In the cycle after the final beat of a transfer is accepted, `irq` is high for exactly one cycle. Status bit 0 (done) reads 1 from the following cycle. It is cleared only by writing status with bit 0 set; writing 0 leaves it set.
- R9: A word presented while the FIFO is full sets status bit 1 (error), which stays set. While it is set, every incoming word is dropped and the fill does not grow. Writing status with bit 1 set clears it.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data`, `wr_addr` and `wr_len` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserialized word present |
| rx_data | input | DATA_W | Deserialized word |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select for write |
| cfg_wr_data | input | ADDR_W | Register write value |
| cfg_rd_sel | input | 2 | Register select for read |
| cfg_rd_data | output | ADDR_W | Register read value |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_sop | output | 1 | First beat of a burst |
| wr_addr | output | ADDR_W | Burst start byte address |
| wr_len | output | $clog2(MAX_BURST+1) | Burst length in beats |
| wr_data | output | DATA_W | Beat data |
| wr_last | output | 1 | Final beat of a burst |
| irq | output | 1 | Transfer-complete pulse |

## Verification
The bench builds the engine with FIFO_DEPTH = 16 and MAX_BURST = 8 and keeps the real 4096-byte line. With these values a 16-word transfer splits into up to three bursts, so the burst splitter's limits on length, words left and line room all come into play. A full FIFO, and with it the overflow path, is reached after a handful of pushes. Random destinations, some placed just below a 4 KB line and some with junk in bits [1:0], are mixed with a randomly throttled `wr_ready`. This exercises the line split, address alignment and the stall-hold rule together.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2
    } dma_state_e;

    localparam logic [1:0] SEL_DEST = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_FILL = 2'd3;

    localparam int STAT_DONE = 0;
    localparam int STAT_ERR  = 1;
    localparam int STAT_BUSY = 2;

endpackage

// File: rtl/dma_rx_fifo.sv
module dma_rx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              drop_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t q, n;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, push;

    always_comb begin
        n    = q;
        full = (q.count == CNT_W'(DEPTH));
        push = in_valid && !drop_i && !full;
        if (push) n.wr_ptr = q.wr_ptr + PTR_W'(1);
        if (pop_i) n.rd_ptr = q.rd_ptr + PTR_W'(1);
        n.count = q.count + CNT_W'(push) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wr_ptr] <= in_data;
    end

    assign head_o  = mem[q.rd_ptr];
    assign count_o = q.count;
    assign ovf_o   = in_valid && full;

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (q.count != '0));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(DEPTH));

    p_drop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i && !pop_i) |=> (q.count == $past(q.count)));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              done_evt,
    input  logic              ovf_evt,
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  fill_i,
    output logic [ADDR_W-1:0] dest_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              err_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] dest;
        logic [SIZE_W-1:0] size;
        logic              done;
        logic              err;
    } regs_st_t;

    regs_st_t q, n;
    logic stat_wr;

    always_comb begin
        n       = q;
        stat_wr = wr_en && (wr_sel == SEL_STAT);
        if (wr_en && wr_sel == SEL_DEST) n.dest = wr_data;
        if (wr_en && wr_sel == SEL_SIZE) n.size = wr_data[SIZE_W-1:0];
        // set has priority over a same-cycle clear
        n.done = done_evt || (q.done && !(stat_wr && wr_data[STAT_DONE]));
        n.err  = ovf_evt  || (q.err  && !(stat_wr && wr_data[STAT_ERR]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_DEST: rd_data = q.dest;
            SEL_SIZE: rd_data = ADDR_W'(q.size);
            SEL_STAT: rd_data = ADDR_W'({busy_i, q.err, q.done});
            default:  rd_data = ADDR_W'(fill_i);
        endcase
    end

    assign dest_o = q.dest;
    assign size_o = q.size;
    assign err_o  = q.err;

    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> q.done);

    p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> q.err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !stat_wr) |=> q.err);

endmodule

// File: rtl/dma_burst.sv
module dma_burst
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int CNT_W     = 7,
    parameter int MAX_BURST = 32,
    parameter int BOUNDARY  = 4096,
    localparam int BYTES    = DATA_W / 8,
    localparam int BSH      = $clog2(BYTES),
    localparam int LEN_W    = $clog2(MAX_BURST + 1),
    localparam int BND_W    = $clog2(BOUNDARY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [CNT_W-1:0]  fill_i,
    input  logic [DATA_W-1:0] head_i,
    output logic              pop_o,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              wr_sop,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LEN_W-1:0]  wr_len,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              busy_o,
    output logic              done_o
);

    typedef struct packed {
        dma_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] bstart;
        logic [SIZE_W-1:0] remain;
        logic [LEN_W-1:0]  blen;
        logic [LEN_W-1:0]  left;
        logic              first;
        logic              done;
    } burst_st_t;

    burst_st_t q, n;
    logic [SIZE_W-1:0] size_words;
    logic              trigger;
    logic [31:0]       room, take;

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        pop_o      = 1'b0;
        size_words = size_i >> BSH;
        trigger    = (size_words != '0) && (32'(fill_i) >= 32'(size_words));
        room       = (32'(BOUNDARY) - 32'(q.addr[BND_W-1:0])) >> BSH;
        take       = 32'(q.remain);
        if (take > 32'(MAX_BURST)) take = 32'(MAX_BURST);
        if (take > room)           take = room;
        case (q.state)
            ST_IDLE: begin
                if (trigger) begin
                    n.state  = ST_SETUP;
                    n.addr   = dest_i & ~ADDR_W'(BYTES - 1);
                    n.remain = size_words;
                end
            end
            ST_SETUP: begin
                n.blen   = LEN_W'(take);
                n.left   = LEN_W'(take);
                n.bstart = q.addr;
                n.first  = 1'b1;
                n.state  = ST_DATA;
            end
            ST_DATA: begin
                if (wr_ready) begin
                    pop_o    = 1'b1;
                    n.addr   = q.addr + ADDR_W'(BYTES);
                    n.remain = q.remain - SIZE_W'(1);
                    n.left   = q.left - LEN_W'(1);
                    n.first  = 1'b0;
                    if (q.left == LEN_W'(1)) begin
                        if (q.remain == SIZE_W'(1)) begin
                            n.state = ST_IDLE;
                            n.done  = 1'b1;
                        end else begin
                            n.state = ST_SETUP;
                        end
                    end
                end
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign wr_valid = (q.state == ST_DATA);
    assign wr_sop   = q.first;
    assign wr_addr  = q.bstart;
    assign wr_len   = q.blen;
    assign wr_data  = head_i;
    assign wr_last  = (q.left == LEN_W'(1));
    assign busy_o   = (q.state != ST_IDLE);
    assign done_o   = q.done;

    p_len_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sop) |-> (wr_len != '0 && 32'(wr_len) <= 32'(MAX_BURST)));

    p_no_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sop) |->
        (32'(wr_addr[BND_W-1:0]) + 32'(wr_len) * 32'(BYTES) <= 32'(BOUNDARY)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
        (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(wr_len)));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_zero_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && size_words == '0) |=> (q.state == ST_IDLE));

endmodule

// File: rtl/thr_dma_wr.sv
module thr_dma_wr
    import dma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int FIFO_DEPTH = 64,
    parameter int MAX_BURST  = 32,
    parameter int BOUNDARY   = 4096
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_valid,
    input  logic [DATA_W-1:0]                rx_data,
    input  logic                             cfg_wr_en,
    input  logic [1:0]                       cfg_wr_sel,
    input  logic [ADDR_W-1:0]                cfg_wr_data,
    input  logic [1:0]                       cfg_rd_sel,
    output logic [ADDR_W-1:0]                cfg_rd_data,
    output logic                             wr_valid,
    input  logic                             wr_ready,
    output logic                             wr_sop,
    output logic [ADDR_W-1:0]                wr_addr,
    output logic [$clog2(MAX_BURST+1)-1:0]   wr_len,
    output logic [DATA_W-1:0]                wr_data,
    output logic                             wr_last,
    output logic                             irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic              ovf, pop, err, busy, done;
    logic [ADDR_W-1:0] dest;
    logic [SIZE_W-1:0] size;

    dma_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .drop_i   (err),
        .pop_i    (pop),
        .head_o   (head),
        .count_o  (fill),
        .ovf_o    (ovf)
    );

    dma_regs #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .rd_sel   (cfg_rd_sel),
        .rd_data  (cfg_rd_data),
        .done_evt (done),
        .ovf_evt  (ovf),
        .busy_i   (busy),
        .fill_i   (fill),
        .dest_o   (dest),
        .size_o   (size),
        .err_o    (err)
    );

    dma_burst #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SIZE_W    (SIZE_W),
        .CNT_W     (CNT_W),
        .MAX_BURST (MAX_BURST),
        .BOUNDARY  (BOUNDARY)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .dest_i   (dest),
        .size_i   (size),
        .fill_i   (fill),
        .head_i   (head),
        .pop_o    (pop),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_sop   (wr_sop),
        .wr_addr  (wr_addr),
        .wr_len   (wr_len),
        .wr_data  (wr_data),
        .wr_last  (wr_last),
        .busy_o   (busy),
        .done_o   (done)
    );

    assign irq = done;

endmodule

// File: tb/tb_thr_dma_wr.sv
module tb_thr_dma_wr;

    localparam int DEPTH = 16;
    localparam int MB    = 8;
    localparam int LW    = $clog2(MB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0] cfg_rd_sel = '0;
    logic [31:0] cfg_rd_data;
    logic wr_valid, wr_sop, wr_last, irq;
    logic wr_ready = 1'b0;
    logic [31:0] wr_addr, wr_data;
    logic [LW-1:0] wr_len;

    thr_dma_wr #(
        .FIFO_DEPTH (DEPTH),
        .MAX_BURST  (MB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sop(wr_sop), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_data(wr_data), .wr_last(wr_last), .irq(irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int ready_pct = 100;
    logic [31:0] exp_data[$];
    logic [31:0] pend_addr[$];
    int unsigned pend_words[$];
    bit cur_active = 0;
    logic [31:0] cur_addr;
    int unsigned cur_left, burst_left;
    int beats = 0;
    int sops = 0;
    int irq_cnt = 0;
    int xfers = 0;
    bit irq_prev = 0;
    bit stall_pend = 0;
    logic [31:0] stall_data, stall_addr;
    logic [LW-1:0] stall_len;
    logic [31:0] rv;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned burst_len(input logic [31:0] a, input int unsigned w);
        int unsigned room, t;
        room = (4096 - (a & 32'hFFF)) / 4;
        t = w;
        if (t > MB) t = MB;
        if (t > room) t = room;
        return t;
    endfunction

    // output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) begin
                irq_cnt++;
                if (irq_prev) chk(1'b0, "R8 irq wider than one cycle", 32'd1, 32'd0);
            end
            irq_prev = irq;
            if (stall_pend)
                chk(wr_valid && wr_data == stall_data && wr_addr == stall_addr && wr_len == stall_len,
                    "R10 stalled beat held", wr_data, stall_data);
            stall_pend = wr_valid && !wr_ready;
            stall_data = wr_data;
            stall_addr = wr_addr;
            stall_len  = wr_len;
            if (wr_valid && wr_ready) begin
                if (!cur_active) begin
                    if (pend_addr.size() == 0) begin
                        chk(1'b0, "R3 unexpected transfer start", wr_addr, 32'd0);
                        cur_addr = wr_addr;
                        cur_left = 1;
                    end else begin
                        cur_addr = pend_addr.pop_front();
                        cur_left = pend_words.pop_front();
                    end
                    cur_active = 1;
                    burst_left = 0;
                end
                if (burst_left == 0) begin
                    chk(wr_sop && wr_addr == cur_addr, "R6 burst start address", wr_addr, cur_addr);
                    burst_left = burst_len(cur_addr, cur_left);
                    chk(32'(wr_len) == burst_left, "R6 burst length", 32'(wr_len), burst_left);
                    sops++;
                end else begin
                    chk(!wr_sop, "R6 sop only on first beat", 32'(wr_sop), 32'd0);
                end
                if (exp_data.size() == 0) chk(1'b0, "R5 beat with no data expected", wr_data, 32'd0);
                else begin
                    logic [31:0] e;
                    e = exp_data.pop_front();
                    chk(wr_data == e, "R5 data order", wr_data, e);
                end
                chk(wr_last == (burst_left == 1), "R6 last flag", 32'(wr_last), 32'(burst_left == 1));
                cur_addr = cur_addr + 4;
                cur_left--;
                burst_left--;
                beats++;
                if (cur_left == 0) begin
                    cur_active = 0;
                    xfers++;
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            wr_ready = ($urandom_range(99) < ready_pct);
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        cfg_rd_sel = sel;
        #1;
        v = cfg_rd_data;
    endtask

    task automatic push_words(input int n, input bit accept);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_data  = $urandom;
            if (accept) exp_data.push_back(rx_data);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic expect_xfer(input logic [31:0] a, input int unsigned w);
        pend_addr.push_back(a & 32'hFFFF_FFFC);
        pend_words.push_back(w);
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((exp_data.size() != 0 || cur_active || pend_addr.size() != 0) && t < 5000) begin
            @(posedge clk);
            t++;
        end
        chk(t < 5000, "R5 transfer drained", t, 32'd0);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(!wr_valid && !irq, "R1 outputs idle after reset", {wr_valid, irq}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), rv);
            chk(rv == 0, "R1 register reads zero after reset", rv, 32'd0);
        end

        // R2 register readback
        cfg_write(2'd0, 32'h1234_5679);
        cfg_read(2'd0, rv);
        chk(rv == 32'h1234_5679, "R2 destination readback", rv, 32'h1234_5679);
        cfg_write(2'd1, 32'h0000_0003);
        cfg_read(2'd1, rv);
        chk(rv == 32'h3, "R2 size readback", rv, 32'h3);

        // R4 size below one word: no trigger, words kept
        push_words(5, 1'b1);
        repeat (20) @(posedge clk);
        cfg_read(2'd3, rv);
        chk(rv == 5, "R4 fill kept with zero-word size", rv, 32'd5);
        chk(beats == 0, "R4 no beats with zero-word size", beats, 32'd0);
        cfg_write(2'd0, 32'h1000_0100);
        expect_xfer(32'h1000_0100, 5);
        cfg_write(2'd1, 32'd20);
        wait_idle();
        chk(beats == 5, "R5 beat count of size", beats, 32'd5);
        chk(irq_cnt == 1, "R8 one irq per transfer", irq_cnt, 32'd1);
        cfg_read(2'd2, rv);
        chk(rv[0] == 1'b1 && rv[2] == 1'b0, "R8 done set, busy clear", rv, 32'd1);
        cfg_write(2'd2, 32'd0);
        cfg_read(2'd2, rv);
        chk(rv[0] == 1'b1, "R8 writing zero keeps done", rv, 32'd1);
        cfg_write(2'd2, 32'd1);
        cfg_read(2'd2, rv);
        chk(rv[0] == 1'b0, "R8 done cleared by write one", rv, 32'd0);

        // R3 threshold: one short of size does not trigger
        ready_pct = 70;
        cfg_write(2'd0, 32'h0000_8000);
        cfg_write(2'd1, 32'd32);
        push_words(7, 1'b1);
        repeat (20) @(posedge clk);
        cfg_read(2'd3, rv);
        chk(rv == 7, "R3 fill one below size", rv, 32'd7);
        chk(beats == 5, "R3 no beats below threshold", beats, 32'd5);
        expect_xfer(32'h0000_8000, 8);
        push_words(1, 1'b1);
        wait_idle();
        chk(beats == 13, "R3 transfer at threshold", beats, 32'd13);
        cfg_write(2'd2, 32'd1);

        // R6 crossing a 4 KB line
        sops = 0;
        cfg_write(2'd0, 32'h0000_0FF0);
        cfg_write(2'd1, 32'd64);
        expect_xfer(32'h0000_0FF0, 16);
        push_words(16, 1'b1);
        wait_idle();
        chk(sops == 3, "R6 split into three bursts at line", sops, 32'd3);
        cfg_write(2'd2, 32'd1);

        // R7 register writes during a transfer
        ready_pct = 30;
        cfg_write(2'd0, 32'h0000_2000);
        cfg_write(2'd1, 32'd48);
        expect_xfer(32'h0000_2000, 12);
        push_words(12, 1'b1);
        begin
            int t = 0;
            rv = 0;
            while (rv[2] == 1'b0 && t < 200) begin
                cfg_read(2'd2, rv);
                t++;
            end
        end
        cfg_write(2'd0, 32'h0000_3000);
        cfg_write(2'd1, 32'd24);
        cfg_read(2'd2, rv);
        chk(rv[2] == 1'b1, "R7 still busy after reprogram", rv, 32'd4);
        wait_idle();
        cfg_read(2'd3, rv);
        chk(rv == 0, "R7 old size used for running transfer", rv, 32'd0);
        expect_xfer(32'h0000_3000, 6);
        push_words(6, 1'b1);
        wait_idle();
        chk(xfers == 5, "R7 new values used for next transfer", xfers, 32'd5);
        cfg_write(2'd2, 32'd1);

        // R9 overflow
        ready_pct = 100;
        cfg_write(2'd1, 32'd0);
        push_words(DEPTH, 1'b1);
        cfg_read(2'd2, rv);
        chk(rv[1] == 1'b0, "R9 no error at exactly full", rv, 32'd0);
        push_words(3, 1'b0);
        cfg_read(2'd2, rv);
        chk(rv[1] == 1'b1, "R9 error set on overflow", rv, 32'd2);
        cfg_read(2'd3, rv);
        chk(rv == DEPTH, "R9 fill capped at depth", rv, DEPTH);
        cfg_write(2'd0, 32'h0004_0000);
        expect_xfer(32'h0004_0000, DEPTH);
        cfg_write(2'd1, 32'(DEPTH * 4));
        wait_idle();
        push_words(2, 1'b0);
        cfg_read(2'd3, rv);
        chk(rv == 0, "R9 words dropped while error set", rv, 32'd0);
        cfg_read(2'd2, rv);
        chk(rv[1] == 1'b1, "R9 error sticky", rv, 32'd2);
        cfg_write(2'd2, 32'd2);
        cfg_read(2'd2, rv);
        chk(rv[1] == 1'b0, "R9 error cleared by write one", rv, 32'd0);
        push_words(2, 1'b1);
        cfg_read(2'd3, rv);
        chk(rv == 2, "R9 words accepted after clear", rv, 32'd2);
        cfg_write(2'd0, 32'h0005_0000);
        expect_xfer(32'h0005_0000, 2);
        cfg_write(2'd1, 32'd8);
        wait_idle();
        cfg_write(2'd2, 32'd3);

        // random transfers (R2 low bits, R5, R6, R8, R10)
        for (int it = 0; it < 30; it++) begin
            int unsigned w;
            logic [31:0] d, sz;
            int prev_irq;
            w = $urandom_range(1, 16);
            if ($urandom_range(2) == 0)
                d = ($urandom & 32'hFFFF_F000) + 32'h1000 - 32'($urandom_range(1, 12) * 4)
                    + 32'($urandom_range(0, 3));
            else
                d = $urandom;
            sz = 32'(w * 4 + $urandom_range(0, 3));
            ready_pct = $urandom_range(20, 100);
            prev_irq = irq_cnt;
            cfg_write(2'd0, d);
            cfg_write(2'd1, sz);
            expect_xfer(d, w);
            push_words(int'(w), 1'b1);
            wait_idle();
            cfg_read(2'd2, rv);
            chk(rv[0] == 1'b1 && rv[2] == 1'b0, "R8 done after random transfer", rv, 32'd1);
            chk(irq_cnt == prev_irq + 1, "R8 irq count random transfer", irq_cnt, prev_irq + 1);
            cfg_write(2'd2, 32'd1);
            cfg_write(2'd1, 32'd0);
        end

        chk(exp_data.size() == 0, "R5 all received words written", exp_data.size(), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule